// File: doc/BRIEF.md
# Attribute-Coloured Pixel Serializer

This block turns a stream of screen bytes into one 3-bit RGB value per clock. A bitmap byte becomes eight pixels, sent most significant bit first. Each pixel lasts one clock in the narrow-pixel mode (eight clocks per byte) or two clocks in the wide-pixel mode (sixteen clocks per byte). A scan line starts with a one-cycle `line_go` pulse. One column period of dark output follows, which leaves time to deliver the first column's data. After it come `COLS` columns of pixels, and then the output goes dark again.

With attributes switched on, the fetch logic upstream places colour attribute bytes in slots that bitmap reads leave free. The serializer stores them in a line buffer of `COLS` entries, but only while the character-row line index is zero. The other seven lines of the character row reuse the stored entries. Each column's foreground and background colour are taken at the moment its bitmap byte is loaded into the shifter. In the paired density, one attribute byte serves two neighbouring columns with four bits each, so only half as many attribute slots are used.

Bitmap and attribute bytes may arrive at any time before the column that uses them starts. A byte that lands on the same edge as a column load is kept for the following column.

Top module: `attr_pixel_serializer`

## Requirements
- R1: After reset, and until a `line_go` pulse, `rgb` is 000 whatever bytes are strobed.
- R2: With `wide_x2`=0, bit 7 of a column's bitmap byte is shown first, and each following bit one clock later, so a column lasts 8 clocks.
- R3: With `wide_x2`=1, every bitmap bit is held for 2 clocks, so a column lasts 16 clocks.
- R4: For one column period after the edge that samples `line_go`=1, `rgb` is 000. Column 0's first pixel appears exactly one column period after that edge.
- R5: After `COLS` columns the line ends, and `rgb` stays 000 until the next `line_go`.
- R6: While `blank` is 1, `rgb` is 000 (combinational, same cycle).
- R7: With `attr_en`=0, a set bitmap bit gives 111 and a clear bit gives 000.
- R8: With `attr_en`=1 and `attr_pair`=0, attribute byte k of the line colours column k. Bits [6:4] are the foreground (set bit) and bits [2:0] the background (clear bit); bits 7 and 3 are ignored.
- R9: With `attr_en`=1 and `attr_pair`=1, attribute byte j colours columns 2j and 2j+1. The even column uses bits [7:4] and the odd column bits [3:0]. In a nibble, bits [2:0] are the foreground. The background is the bitwise inverse of the foreground when nibble bit 3 is set, and 000 when it is clear.
- R10: Attribute bytes are stored only when `row_idx` is 0. On other rows they are ignored, and the colours stored on row 0 are used again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_go | input | 1 | One-cycle pulse that starts a scan line |
| byte_stb | input | 1 | A fetched byte is present on `byte_data` |
| byte_is_attr | input | 1 | Tag: 1 = attribute byte, 0 = bitmap byte |
| byte_data | input | 8 | Fetched byte |
| wide_x2 | input | 1 | 1 = each pixel held two clocks |
| attr_en | input | 1 | Enables attribute colouring |
| attr_pair | input | 1 | 1 = one attribute byte per two columns |
| row_idx | input | 3 | Line index within the character row |
| blank | input | 1 | Forces dark output |
| rgb | output | 3 | Pixel colour, bit 2 red, bit 1 green, bit 0 blue |

## Verification
The hardest case to reach is a character row whose later lines show colours that were delivered lines earlier. On those lines the attribute strobes carry different bytes, and those bytes must have no visible effect. The bench first runs a row-0 line that fills the buffer from one seed. It then runs a row-1 or row-2 line that strobes attributes from a different seed. Each pixel is compared against colours predicted from the first seed only, and this is done in both the per-column and the paired density.

// File: rtl/aps_pkg.sv
// Shared colour types and attribute decode helpers for the pixel serializer.
// Assumes a 3-bit RGB colour with red in bit 2.
package aps_pkg;

    typedef struct packed {
        logic [2:0] fg;
        logic [2:0] bg;
    } aps_colours_t;

    localparam logic [2:0] APS_BLACK = 3'b000;
    localparam logic [2:0] APS_WHITE = 3'b111;

    // Colour pair from explicit foreground and background fields.
    function automatic aps_colours_t aps_from_fields(input logic [2:0] f, input logic [2:0] b);
        aps_colours_t r;
        r.fg = f;
        r.bg = b;
        return r;
    endfunction

    // Colour pair from a 4-bit attribute: bit 3 requests an inverted background.
    function automatic aps_colours_t aps_from_nibble(input logic [3:0] n);
        aps_colours_t r;
        r.fg = n[2:0];
        r.bg = n[3] ? ~n[2:0] : APS_BLACK;
        return r;
    endfunction

endpackage

// File: rtl/aps_timing.sv
// Line sequencer: after line_go runs one dark lead-in column, then COLS pixel
// columns. Emits the column-load strobe, the index of the column being loaded
// and the pixel-advance strobe. Assumes wide_x2 is steady during a line.
module aps_timing #(
    parameter int COLS = 40,
    parameter int CW   = $clog2(COLS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_go,
    input  logic          wide_x2,
    output logic          running,
    output logic          in_lead,
    output logic          col_load,
    output logic          pix_adv,
    output logic [CW-1:0] load_col,
    output logic [3:0]    sub
);
    localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

    logic [CW-1:0] col;
    logic          slot_end;

    // Last clock of the current column period.
    always_comb slot_end = wide_x2 ? (sub == 4'd15) : (sub == 4'd7);

    // Load the next column at a slot end unless the final column just ended.
    always_comb begin
        col_load = running && slot_end && (in_lead || (col != LAST_COL));
        load_col = in_lead ? '0 : col + CW'(1);
        pix_adv  = running && !in_lead && !slot_end && (wide_x2 ? sub[0] : 1'b1);
    end

    // Position counters for the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            in_lead <= 1'b0;
            sub     <= '0;
            col     <= '0;
        end else if (line_go) begin
            running <= 1'b1;
            in_lead <= 1'b1;
            sub     <= '0;
            col     <= '0;
        end else if (running) begin
            if (slot_end) begin
                sub <= '0;
                if (in_lead) begin
                    in_lead <= 1'b0;
                end else if (col == LAST_COL) begin
                    running <= 1'b0;
                end else begin
                    col <= col + CW'(1);
                end
            end else begin
                sub <= sub + 4'd1;
            end
        end
    end

endmodule

// File: rtl/aps_attr_buf.sv
// Attribute line buffer of COLS bytes. Writes go to consecutive entries from 0,
// restarting at each line_go. The read port is combinational so the value can
// be latched at the column-load edge. Writes past the last entry are dropped.
module aps_attr_buf #(
    parameter int COLS = 40,
    parameter int CW   = $clog2(COLS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_go,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic [CW-1:0] rd_idx,
    output logic [7:0]    rd_data,
    output logic [CW-1:0] wr_ptr
);
    logic [7:0] mem [COLS];

    // Read the addressed entry; out-of-range indices read as zero.
    always_comb rd_data = (int'(rd_idx) < COLS) ? mem[rd_idx] : 8'h00;

    // Write pointer restarts per line and stops at the end of the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n || line_go) begin
            wr_ptr <= '0;
        end else if (wr_en && (int'(wr_ptr) < COLS)) begin
            wr_ptr <= wr_ptr + CW'(1);
        end
    end

    // Storage: one entry per column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < COLS; i++) mem[i] <= 8'h00;
        end else if (wr_en && !line_go && (int'(wr_ptr) < COLS)) begin
            mem[wr_ptr] <= wr_data;
        end
    end

endmodule

// File: rtl/aps_shifter.sv
// Holds the most recent bitmap byte, then at each column load moves it into the
// shift register together with the column's colour pair. Shifts left on each
// pixel advance, so the MSB is the current pixel.
module aps_shifter
    import aps_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bm_wr,
    input  logic [7:0]   bm_data,
    input  logic         col_load,
    input  logic         pix_adv,
    input  aps_colours_t colours_in,
    output logic         pix_bit,
    output aps_colours_t colours_q
);
    logic [7:0] pend;
    logic [7:0] shreg;

    // Capture the next column's bitmap byte.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend <= 8'h00;
        else if (bm_wr) pend <= bm_data;
    end

    // Load or shift the active byte and its colours.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= 8'h00;
            colours_q <= '0;
        end else if (col_load) begin
            shreg     <= pend;
            colours_q <= colours_in;
        end else if (pix_adv) begin
            shreg <= {shreg[6:0], 1'b0};
        end
    end

    // Current pixel is the top bit.
    always_comb pix_bit = shreg[7];

endmodule

// File: rtl/attr_pixel_serializer.sv
// Top of the attribute-coloured pixel serializer. Sends tagged bytes to the
// bitmap holder or the attribute line buffer, picks each column's colour pair
// and drives the RGB output, which is dark outside the pixel window or when
// blanked. Assumes mode inputs are steady for the length of a line.
module attr_pixel_serializer
    import aps_pkg::*;
#(
    parameter int COLS  = 40,
    parameter int ROW_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_go,
    input  logic             byte_stb,
    input  logic             byte_is_attr,
    input  logic [7:0]       byte_data,
    input  logic             wide_x2,
    input  logic             attr_en,
    input  logic             attr_pair,
    input  logic [ROW_W-1:0] row_idx,
    input  logic             blank,
    output logic [2:0]       rgb
);
    localparam int CW = $clog2(COLS + 1);

    logic          running, in_lead, col_load, pix_adv;
    logic [CW-1:0] load_col, rd_idx, wr_ptr;
    logic [3:0]    sub;
    logic [7:0]    attr_rd;
    logic          attr_wr, bm_wr, pix_bit, pix_on;
    aps_colours_t  colours_next, colours_q;

    // Route strobed bytes by their tag; attributes only on the first line.
    always_comb begin
        attr_wr = byte_stb && byte_is_attr && attr_en && (row_idx == '0);
        bm_wr   = byte_stb && !byte_is_attr;
    end

    aps_timing #(.COLS(COLS), .CW(CW)) u_timing (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_go  (line_go),
        .wide_x2  (wide_x2),
        .running  (running),
        .in_lead  (in_lead),
        .col_load (col_load),
        .pix_adv  (pix_adv),
        .load_col (load_col),
        .sub      (sub)
    );

    // Paired density shares one buffer entry between two columns.
    always_comb rd_idx = attr_pair ? (load_col >> 1) : load_col;

    aps_attr_buf #(.COLS(COLS), .CW(CW)) u_attr_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_go (line_go),
        .wr_en   (attr_wr),
        .wr_data (byte_data),
        .rd_idx  (rd_idx),
        .rd_data (attr_rd),
        .wr_ptr  (wr_ptr)
    );

    // Colour pair for the column about to be loaded.
    always_comb begin
        if (!attr_en)
            colours_next = aps_from_fields(APS_WHITE, APS_BLACK);
        else if (attr_pair)
            colours_next = aps_from_nibble(load_col[0] ? attr_rd[3:0] : attr_rd[7:4]);
        else
            colours_next = aps_from_fields(attr_rd[6:4], attr_rd[2:0]);
    end

    aps_shifter u_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .bm_wr      (bm_wr),
        .bm_data    (byte_data),
        .col_load   (col_load),
        .pix_adv    (pix_adv),
        .colours_in (colours_next),
        .pix_bit    (pix_bit),
        .colours_q  (colours_q)
    );

    // Final pixel colour with window and blank gating.
    always_comb begin
        pix_on = running && !in_lead && !blank;
        rgb    = pix_on ? (pix_bit ? colours_q.fg : colours_q.bg) : APS_BLACK;
    end

endmodule

// File: rtl/attr_pixel_serializer_chk.sv
// Property checker for the pixel serializer, bound into every instance.
module attr_pixel_serializer_chk #(
    parameter int CW    = 6,
    parameter int ROW_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_go,
    input logic             blank,
    input logic             wide_x2,
    input logic [ROW_W-1:0] row_idx,
    input logic [2:0]       rgb,
    input logic             running,
    input logic             in_lead,
    input logic [3:0]       sub,
    input logic [CW-1:0]    wr_ptr
);
    AST_LEAD_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(line_go) |-> (rgb == 3'b000)); // R4

    AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (rgb == 3'b000)); // R5

    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (rgb == 3'b000)); // R6

    AST_WIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_x2 && $past(wide_x2) && running && !in_lead && sub[0] && !blank && !$past(blank))
        |-> $stable(rgb)); // R3

    AST_ROW_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        ((row_idx != '0) && !line_go) |=> $stable(wr_ptr)); // R10

endmodule

bind attr_pixel_serializer attr_pixel_serializer_chk #(.CW(CW), .ROW_W(ROW_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_go (line_go),
    .blank   (blank),
    .wide_x2 (wide_x2),
    .row_idx (row_idx),
    .rgb     (rgb),
    .running (running),
    .in_lead (in_lead),
    .sub     (sub),
    .wr_ptr  (wr_ptr)
);

// File: tb/attr_pixel_serializer_bench.sv
// Directed bench: each task runs one scan line and compares every output cycle.
module attr_pixel_serializer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int COLS = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_go = 1'b0;
    logic       byte_stb = 1'b0;
    logic       byte_is_attr = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       wide_x2 = 1'b0;
    logic       attr_en = 1'b0;
    logic       attr_pair = 1'b0;
    logic [2:0] row_idx = 3'd0;
    logic       blank = 1'b0;
    logic [2:0] rgb;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    logic [7:0] bm    [COLS];
    logic [7:0] at_in [COLS];
    logic [7:0] at_mem[COLS];

    always #(CLK_PERIOD/2) clk = ~clk;

    attr_pixel_serializer #(.COLS(COLS)) u_attr_pixel_serializer (
        .clk(clk), .rst_n(rst_n), .line_go(line_go), .byte_stb(byte_stb),
        .byte_is_attr(byte_is_attr), .byte_data(byte_data), .wide_x2(wide_x2),
        .attr_en(attr_en), .attr_pair(attr_pair), .row_idx(row_idx),
        .blank(blank), .rgb(rgb)
    );

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp, input int pos);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: rgb actual %b expected %b", req, pos, act, exp);
        end
    endtask

    task automatic check_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", rgb, 3'b000, 0);
        for (int i = 0; i < 20; i++) begin
            byte_stb = 1'b1; byte_is_attr = i[0]; byte_data = 8'hFF;
            @(negedge clk);
            #1;
            chk("R1", rgb, 3'b000, i);
        end
        byte_stb = 1'b0;
    endtask

    // One full line; blank is raised for cycles blo..bhi.
    task automatic run_line(input bit x2, input bit aen, input bit half, input logic [2:0] row,
                            input int seed, input int blo, input int bhi, input string tag);
        int s  = x2 ? 2 : 1;
        int L  = 8 * s;
        int nmax = L + COLS * L + 3;
        for (int c = 0; c < COLS; c++) begin
            bm[c]    = 8'((c * 37 + seed * 11) ^ (c << 3));
            at_in[c] = 8'(c * 53 + seed * 29 + 5);
        end
        if (aen && row == 3'd0) begin
            for (int c = 0; c < COLS; c++) begin
                if (!half) at_mem[c] = at_in[c];
                else if (c % 2 == 0) at_mem[c/2] = at_in[c];
            end
        end
        @(negedge clk);
        wide_x2 = x2; attr_en = aen; attr_pair = half; row_idx = row;
        line_go = 1'b1;
        for (int n = 0; n <= nmax; n++) begin
            @(negedge clk);
            line_go = 1'b0;
            blank = (n >= blo) && (n <= bhi);
            #1;
            begin
                logic [2:0] exp;
                string req;
                if (n < L) begin
                    exp = 3'b000; req = "R4";
                end else if ((n - L) / L >= COLS) begin
                    exp = 3'b000; req = "R5";
                end else if (blank) begin
                    exp = 3'b000; req = "R6";
                end else begin
                    int m = n - L;
                    int c = m / L;
                    int k = (m % L) / s;
                    logic b = bm[c][7-k];
                    logic [2:0] fg, bg;
                    if (!aen) begin
                        fg = 3'b111; bg = 3'b000;
                    end else if (half) begin
                        logic [3:0] nib = (c % 2 == 0) ? at_mem[c/2][7:4] : at_mem[c/2][3:0];
                        fg = nib[2:0]; bg = nib[3] ? ~nib[2:0] : 3'b000;
                    end else begin
                        fg = at_mem[c][6:4]; bg = at_mem[c][2:0];
                    end
                    exp = b ? fg : bg;
                    req = tag;
                end
                chk(req, rgb, exp, n);
            end
            // Strobes for the next edge: bitmap at slot offset 1, attribute at 2.
            begin
                int j = n + 1;
                int t = (j < L) ? 0 : ((j - L) / L + 1);
                int o = j % L;
                byte_stb = 1'b0; byte_is_attr = 1'b0;
                if (t < COLS && o == 1) begin
                    byte_stb = 1'b1; byte_data = bm[t];
                end else if (t < COLS && o == 2 && aen && (!half || t % 2 == 0)) begin
                    byte_stb = 1'b1; byte_is_attr = 1'b1; byte_data = at_in[t];
                end
            end
        end
        byte_stb = 1'b0;
        blank = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < COLS; c++) at_mem[c] = 8'h00;
        check_reset();
        run_line(1'b0, 1'b0, 1'b0, 3'd0, 1, -1, -1, "R2 R7");    // narrow, mono
        run_line(1'b1, 1'b0, 1'b0, 3'd0, 2, -1, -1, "R3 R7");    // wide, mono
        run_line(1'b1, 1'b1, 1'b0, 3'd0, 3, 100, 140, "R8");     // full attributes, blank window R6
        run_line(1'b1, 1'b1, 1'b0, 3'd1, 9, -1, -1, "R10");      // row 1 strobes ignored
        run_line(1'b1, 1'b1, 1'b1, 3'd0, 5, -1, -1, "R9");       // paired attributes
        run_line(1'b1, 1'b1, 1'b1, 3'd2, 11, 300, 305, "R10");   // paired, row 2 ignored
        run_line(1'b0, 1'b1, 1'b0, 3'd0, 7, -1, -1, "R2 R8");    // narrow with attributes
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule